// File: doc/BRIEF.md
# Infrared Pulse-Width Frame Decoder

The block turns a demodulated, idle-high infrared receiver signal into a data word of up to twelve bits. A frame opens with a long low start pulse. Each bit after it is a short high phase followed by a low phase. A short low phase encodes a zero and a long one encodes a one. The block passes the input through a synchronizer and waits for the line to go low. It starts timing on the rising edge that ends the start pulse. From then on it measures every high/low pair in ticks of a programmable prescaler and stores both widths.

The threshold between zero and one is not fixed. While the frame runs, the block keeps the smallest and the largest pair sum. At the end of the frame it places the threshold halfway between them, then compares every stored pair sum against it, one pair per clock. A frame ends after twelve pairs. It also ends early when a high phase outlasts the full tick counter range; the pairs captured up to that point are kept. When a frame ends, the block raises a one-clock done strobe together with the word, the pair count and the threshold. The stored widths can be read back by index.

Top module: `ir_pulse_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, done_o is 0 and word_o, count_o and thresh_o are all zero.
- R2: The decoder waits for the synchronized input to be low, then starts timing on the rising edge that ends that low pulse. The first stored high width is measured from this edge.
- R3: A phase that lasts D clocks at the input is stored as floor((D-1)/CLK_PER_TICK) ticks. rd_idx_i = k returns pair k, with its high width on rd_hi_o and its low width on rd_lo_o, for every k below count_o.
- R4: A low phase longer than the counter range reads as 2^CNT_W-1, the saturated value. It does not wrap.
- R5: thresh_o equals ((max_sum - min_sum) >> 1) + min_sum, where the sums are high width plus low width over all pairs of the frame.
- R6: A pair whose sum is greater than or equal to the threshold decodes as 1, and a smaller sum decodes as 0. When all sums are equal, every bit is 1.
- R7: Pair k of the frame, counted from 0, lands in word_o bit k. The first pair is therefore the least significant bit.
- R8: After MAX_BITS pairs the frame ends. done_o is high after the (count+4)th rising clock edge that follows the input change ending the last pair, and count_o never exceeds MAX_BITS.
- R9: A high phase that lasts 2^CNT_W ticks ends the frame with the pairs captured so far. done_o then follows 2^CNT_W*CLK_PER_TICK + count + 4 edges after the rising input change. A frame with no pairs reports word 0, count 0 and threshold 0.
- R10: done_o is high for exactly one clock. word_o, count_o and thresh_o keep their values until the next done.
- R11: The minimum and maximum are reset for every frame, so the extremes of an earlier frame have no effect on the next threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated infrared line, idle high |
| rd_idx_i | input | IDX_W | Pair index for width readback |
| done_o | output | 1 | One-clock strobe at the end of a frame |
| word_o | output | MAX_BITS | Decoded word, first pair in bit 0 |
| count_o | output | IDX_W | Number of pairs captured |
| thresh_o | output | CNT_W+1 | Threshold computed for the frame |
| rd_hi_o | output | CNT_W | High-phase width of pair rd_idx_i, in ticks |
| rd_lo_o | output | CNT_W | Low-phase width of pair rd_idx_i, in ticks |

## Verification
Every input change reaches the control logic two clocks later, through the two synchronizer stages, and acts on the third edge. From that edge the threshold takes one cycle and the decode takes one cycle per pair. The done strobe is therefore due count+4 edges after the last rising input change, with a further 2^CNT_W*CLK_PER_TICK edges when a timeout ends the frame. The bench drives the input on falling edges and notes the cycle number of the last rising change. On every falling edge it compares done_o against that predicted cycle, so an early, late or repeated strobe is reported. Width readback is combinational, so it is sampled a fraction of a cycle after the index is applied.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HIGH,
    ST_LOW,
    ST_THRESH,
    ST_DECODE
  } ir_state_e;
endpackage

// File: rtl/ir_sync_edge.sv
module ir_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/ir_tick_timer.sv
module ir_tick_timer #(
  parameter int CLK_PER_TICK = 2000,
  parameter int CNT_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] width_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] W_MAX = '1;

  logic             tick;
  logic [CNT_W-1:0] width_q;

  generate
    if (CLK_PER_TICK <= 1) begin : g_no_pre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int             PRE_W    = $clog2(CLK_PER_TICK);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_TICK - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          pre_q <= '0;
        else if (clr_i || pre_q == PRE_LAST)  pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == PRE_LAST);
    end
  endgenerate

  // saturating width counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          width_q <= '0;
    else if (clr_i)                       width_q <= '0;
    else if (tick && width_q != W_MAX)    width_q <= width_q + 1'b1;
  end

  assign width_o = width_q;
  assign wrap_o  = tick && (width_q == W_MAX) && !clr_i;
endmodule

// File: rtl/ir_pair_store.sv
module ir_pair_store #(
  parameter int MAX_BITS = 12,
  parameter int CNT_W    = 8,
  parameter int IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_hi_i,
  input  logic             we_lo_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] dec_idx_i,
  output logic [CNT_W:0]   dec_sum_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_hi_o,
  output logic [CNT_W-1:0] rd_lo_o
);
  logic [CNT_W-1:0] hi_q [MAX_BITS];
  logic [CNT_W-1:0] lo_q [MAX_BITS];

  generate
    for (genvar g = 0; g < MAX_BITS; g++) begin : g_entry
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hi_q[g] <= '0;
          lo_q[g] <= '0;
        end else begin
          if (we_hi_i && wr_idx_i == IDX_W'(g)) hi_q[g] <= wr_data_i;
          if (we_lo_i && wr_idx_i == IDX_W'(g)) lo_q[g] <= wr_data_i;
        end
      end
    end
  endgenerate

  always_comb begin
    dec_sum_o = '0;
    rd_hi_o   = '0;
    rd_lo_o   = '0;
    for (int k = 0; k < MAX_BITS; k++) begin
      if (dec_idx_i == IDX_W'(k)) dec_sum_o = {1'b0, hi_q[k]} + {1'b0, lo_q[k]};
      if (rd_idx_i == IDX_W'(k)) begin
        rd_hi_o = hi_q[k];
        rd_lo_o = lo_q[k];
      end
    end
  end
endmodule

// File: rtl/ir_pulse_decoder.sv
module ir_pulse_decoder
  import ir_dec_pkg::*;
#(
  parameter int CLK_PER_TICK = 2000,
  parameter int MAX_BITS     = 12,
  parameter int CNT_W        = 8,
  localparam int SUM_W       = CNT_W + 1,
  localparam int IDX_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ir_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] word_o,
  output logic [IDX_W-1:0]    count_o,
  output logic [SUM_W-1:0]    thresh_o,
  output logic [CNT_W-1:0]    rd_hi_o,
  output logic [CNT_W-1:0]    rd_lo_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_BITS - 1);

  logic lvl, rise, fall;
  logic [CNT_W-1:0] tmr_width;
  logic             tmr_wrap;

  ir_state_e            state_q;
  logic [IDX_W-1:0]     idx_q, dec_k_q;
  logic [CNT_W-1:0]     p1_q;
  logic [SUM_W-1:0]     min_q, max_q, thr_q;
  logic [SUM_W-1:0]     pair_sum, dec_sum;
  logic [MAX_BITS-1:0]  word_acc_q, word_nxt;
  logic                 dec_bit, dec_last, we_hi, we_lo;

  ir_sync_edge #(.STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (ir_i),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  ir_tick_timer #(.CLK_PER_TICK(CLK_PER_TICK), .CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rise | fall),
    .width_o (tmr_width),
    .wrap_o  (tmr_wrap)
  );

  assign we_hi = (state_q == ST_HIGH) && fall;
  assign we_lo = (state_q == ST_LOW) && rise;

  ir_pair_store #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_hi_i   (we_hi),
    .we_lo_i   (we_lo),
    .wr_idx_i  (idx_q),
    .wr_data_i (tmr_width),
    .dec_idx_i (dec_k_q),
    .dec_sum_o (dec_sum),
    .rd_idx_i  (rd_idx_i),
    .rd_hi_o   (rd_hi_o),
    .rd_lo_o   (rd_lo_o)
  );

  assign pair_sum = {1'b0, p1_q} + {1'b0, tmr_width};
  assign dec_bit  = (dec_sum >= thr_q);
  assign word_nxt = word_acc_q | ({{(MAX_BITS-1){1'b0}}, dec_bit} << dec_k_q);
  assign dec_last = (dec_k_q == idx_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      dec_k_q    <= '0;
      p1_q       <= '0;
      min_q      <= '1;
      max_q      <= '0;
      thr_q      <= '0;
      word_acc_q <= '0;
      done_o     <= 1'b0;
      word_o     <= '0;
      count_o    <= '0;
      thresh_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          min_q <= '1;
          max_q <= '0;
          if (!lvl) state_q <= ST_START;
        end
        ST_START: begin
          if (rise) state_q <= ST_HIGH;
        end
        ST_HIGH: begin
          if (fall) begin
            p1_q    <= tmr_width;
            state_q <= ST_LOW;
          end else if (tmr_wrap) begin
            state_q <= ST_THRESH;
          end
        end
        ST_LOW: begin
          if (rise) begin
            idx_q <= idx_q + 1'b1;
            if (pair_sum < min_q) min_q <= pair_sum;
            if (pair_sum > max_q) max_q <= pair_sum;
            state_q <= (idx_q == LAST_IDX) ? ST_THRESH : ST_HIGH;
          end
        end
        ST_THRESH: begin
          thr_q      <= ((max_q - min_q) >> 1) + min_q;
          word_acc_q <= '0;
          dec_k_q    <= '0;
          if (idx_q == '0) begin
            done_o   <= 1'b1;
            word_o   <= '0;
            count_o  <= '0;
            thresh_o <= '0;
            state_q  <= ST_IDLE;
          end else begin
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          word_acc_q <= word_nxt;
          dec_k_q    <= dec_k_q + 1'b1;
          if (dec_last) begin
            done_o   <= 1'b1;
            word_o   <= word_nxt;
            count_o  <= idx_q;
            thresh_o <= thr_q;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ir_decoder_chk.sv
module ir_decoder_chk #(
  parameter int MAX_BITS = 12,
  parameter int CNT_W    = 8,
  parameter int IDX_W    = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                done_o,
  input logic [MAX_BITS-1:0] word_o,
  input logic [IDX_W-1:0]    count_o,
  input logic [CNT_W:0]      thresh_o,
  input logic [CNT_W:0]      min_sum,
  input logic [CNT_W:0]      max_sum,
  input logic [CNT_W-1:0]    tick_width
);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(word_o) && $stable(count_o) && $stable(thresh_o)));

  assert_count_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= IDX_W'(MAX_BITS));

  assert_thresh_span_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && count_o != '0) |-> (thresh_o >= min_sum && thresh_o <= max_sum));

  assert_tick_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_width != '0) |->
      (tick_width == $past(tick_width) || tick_width == $past(tick_width) + 1'b1));

  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_width == '1) |=> (tick_width == '1 || tick_width == '0));
endmodule

bind ir_pulse_decoder ir_decoder_chk #(
  .MAX_BITS (MAX_BITS),
  .CNT_W    (CNT_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .word_o     (word_o),
  .count_o    (count_o),
  .thresh_o   (thresh_o),
  .min_sum    (min_q),
  .max_sum    (max_q),
  .tick_width (tmr_width)
);

// File: tb/ir_pulse_decoder_bench.sv
module ir_pulse_decoder_bench;
  localparam int DIV   = 4;
  localparam int NBITS = 12;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_ni;
  logic ir_i;
  logic [IDX_W-1:0] rd_idx_i;
  logic done_o;
  logic [NBITS-1:0] word_o;
  logic [IDX_W-1:0] count_o;
  logic [8:0] thresh_o;
  logic [7:0] rd_hi_o, rd_lo_o;

  always #4 clk = ~clk;

  ir_pulse_decoder #(.CLK_PER_TICK(DIV), .MAX_BITS(NBITS), .CNT_W(8)) u_ir_pulse_decoder (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .ir_i     (ir_i),
    .rd_idx_i (rd_idx_i),
    .done_o   (done_o),
    .word_o   (word_o),
    .count_o  (count_o),
    .thresh_o (thresh_o),
    .rd_hi_o  (rd_hi_o),
    .rd_lo_o  (rd_lo_o)
  );

  int     nchk = 0;
  int     nerr = 0;
  longint cyc = 0;
  longint exp_cyc = -1;
  int     exp_word, exp_cnt, exp_thr;
  int     prev_word = 0;
  int     e_hi [NBITS];
  int     e_lo [NBITS];
  bit     seen_done = 1'b0;
  string  cur_tag = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference comparison on every falling edge
  always @(negedge clk) begin
    if (rst_ni === 1'b1 && (done_o === 1'b1 || cyc == exp_cyc)) begin
      chk(done_o === 1'b1 && cyc == exp_cyc, {cur_tag, " R8 done cycle"}, cyc, exp_cyc);
      chk(word_o == exp_word, {cur_tag, " R7 word"}, word_o, exp_word);
      chk(count_o == exp_cnt, {cur_tag, " count"}, count_o, exp_cnt);
      chk(thresh_o == exp_thr, {cur_tag, " R5 threshold"}, thresh_o, exp_thr);
      prev_word = exp_word;
      exp_cyc   = -1;
      seen_done = 1'b1;
    end
  end

  task automatic hold(input logic lvl, input int d);
    ir_i = lvl;
    repeat (d) @(negedge clk);
  endtask

  task automatic send_frame(input string tag, input int n, input logic [11:0] bits,
                            input int t1, input int jit, input int g0, input int g1);
    int mn, mx, th, wd, gap;
    mn = 511; mx = 0; wd = 0;
    for (int i = 0; i < n; i++) begin
      e_hi[i] = t1 + jit * (i % 3);
      gap     = bits[i] ? g1 : g0;
      e_lo[i] = (gap > 255) ? 255 : gap;
      if (e_hi[i] + e_lo[i] < mn) mn = e_hi[i] + e_lo[i];
      if (e_hi[i] + e_lo[i] > mx) mx = e_hi[i] + e_lo[i];
    end
    th = (n == 0) ? 0 : ((mx - mn) >> 1) + mn;
    for (int i = 0; i < n; i++)
      if (e_hi[i] + e_lo[i] >= th) wd = wd | (1 << i);
    seen_done = 1'b0;
    cur_tag   = tag;
    hold(1'b1, 20);
    hold(1'b0, 162 * DIV + 2);
    chk(word_o == prev_word, "R10 word held during next frame", word_o, prev_word);
    for (int i = 0; i < n; i++) begin
      hold(1'b1, e_hi[i] * DIV + 2);
      hold(1'b0, (bits[i] ? g1 : g0) * DIV + 2);
    end
    ir_i     = 1'b1;
    exp_word = wd;
    exp_cnt  = n;
    exp_thr  = th;
    exp_cyc  = cyc + n + 4 + ((n < NBITS) ? 256 * DIV : 0);
    wait (seen_done);
    hold(1'b1, 10);
  endtask

  task automatic check_widths(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd_idx_i = IDX_W'(k);
      #1;
      chk(rd_hi_o == e_hi[k], "R2 R3 high width", rd_hi_o, e_hi[k]);
      chk(rd_lo_o == e_lo[k], "R3 R4 low width", rd_lo_o, e_lo[k]);
    end
  endtask

  initial begin
    ir_i = 1'b1;
    rd_idx_i = '0;
    rst_ni = 1'b0;
    repeat (5) @(negedge clk);
    chk(done_o == 1'b0 && word_o == 0, "R1 reset outputs", word_o, 0);
    chk(count_o == 0 && thresh_o == 0, "R1 reset count/threshold", thresh_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && word_o == 0 && count_o == 0, "R1 after release", word_o, 0);

    send_frame("basic", 12, 12'hA5C, 25, 0, 50, 87);
    chk(thresh_o == 93, "R5 nominal threshold", thresh_o, 93);
    check_widths(12);
    send_frame("jitter", 12, 12'h3F0, 25, 2, 40, 100);
    send_frame("R9 short timeout", 5, 12'h016, 25, 0, 50, 87);
    check_widths(5);
    send_frame("R6 equal sums", 12, 12'h000, 25, 0, 50, 87);
    chk(word_o == 12'hFFF, "R6 equal sum decodes one", word_o, 12'hFFF);
    send_frame("R4 saturated gap", 12, 12'h00F, 25, 0, 50, 300);
    check_widths(12);
    send_frame("R9 empty frame", 0, 12'h000, 25, 0, 50, 87);
    send_frame("R11 rearm", 12, 12'h5A5, 10, 0, 30, 60);
    send_frame("R7 single one", 12, 12'h001, 25, 0, 50, 87);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule